// File: doc/BRIEF.md
# In-band status byte FIFO

This block is a byte-wide first-in first-out buffer, 128 entries deep by default. It carries its own status inside the data stream, so it needs no flag outputs. A producer pushes a byte with a write strobe. A consumer pulls a byte with a read strobe and finds it on the output in the following cycle. Two byte values have a special meaning on the output. All-zeros is the null byte: it appears when a read finds the buffer empty, and it is also what the path yields after reset. All-ones is the erasure byte: the buffer sends a block of these after it has lost data.

Loss happens when a write arrives while the buffer is full and no read occurs in the same cycle. The incoming byte is then dropped and an overflow latch is set. While the latch is set, every write is discarded. The bytes already stored are still delivered in order. After them, exactly `ERASE_LEN` erasure bytes follow, one per read strobe. The latch then clears and the buffer behaves normally again.

A consumer that finds an erasure byte can therefore strip the run and resynchronise with the producer. It needs no second path to learn that data was lost. Pin-level three-state driving is reduced to an output-enable signal. While that enable is low, the data output reads as zero.

Top module: `inband_fifo`

## Requirements
- R1: Bytes written while the overflow latch is clear and there is room are read back in write order. Each byte appears on `rd_data`, with `rd_oe` high, in the cycle after the clock edge that samples its read strobe. Up to `DEPTH` (128) bytes can be held.
- R2: After reset, `rd_oe` is 0, `rd_data` is 0x00 and the buffer is empty.
- R3: A read strobe that finds the buffer empty while the overflow latch is clear returns 0x00 and consumes nothing.
- R4: A write strobe without a read strobe while the buffer holds `DEPTH` bytes drops the incoming byte and sets the overflow latch. The stored bytes are still delivered unchanged and in order.
- R5: With the latch set, once the stored bytes are exhausted, exactly `ERASE_LEN` (128) read strobes return the erasure byte 0xFF. The latch then clears, and the next read of the empty buffer returns 0x00.
- R6: Every write strobe between the overflowing write and the end of the erasure run is discarded, including writes made after reads have freed room.
- R7: `rd_oe` is 1 exactly in the cycle after a clock edge that samples a read strobe. In every other cycle `rd_oe` is 0 and `rd_data` is 0x00.
- R8: A read and a write strobe in the same cycle while the buffer is full are a normal transfer. The oldest byte is returned, the new byte is stored at the tail, the fill level is unchanged and no overflow is latched.
- R9: After the erasure run has ended, writes are accepted again and read back in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | Write strobe, one byte per cycle in which it is high |
| wr_data | input | WIDTH (8) | Byte to store |
| rd_stb | input | 1 | Read strobe, one byte per cycle in which it is high |
| rd_data | output | WIDTH (8) | Byte read; 0x00 for empty, 0xFF for erasure |
| rd_oe | output | 1 | Output enable, the reduced form of the three-state driver |

## Verification
The assertions assume that both strobes are sampled only at rising edges. They also assume that the strobes are held at defined levels, never unknown, from reset onwards. The properties relate each strobe to the output one edge later, so they need no assumption about how far apart strobes are. The stimulus changes inputs only at falling edges and returns both strobes to zero after every step. It also reads the output a full half period after each edge, so every strobe is a clean single-cycle pulse.

// File: rtl/inband_fifo_pkg.sv
package inband_fifo_pkg;

    // Overflow latch state: clear (normal) or set (data was lost)
    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_LOST = 1'b1
    } ifb_mode_e;

    // What a read strobe returns
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_NULL  = 2'd1,
        SRC_MEM   = 2'd2,
        SRC_ERASE = 2'd3
    } ifb_src_e;

endpackage

// File: rtl/ifb_store.sv
module ifb_store #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata = cells_q[raddr];

endmodule

// File: rtl/ifb_ptrs.sv
module ifb_ptrs #(
    parameter int DEPTH = 128,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] fill,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] fill;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic [AW-1:0] wr_inc, rd_inc;

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            always_comb begin
                wr_inc = st_q.wr + AW'(1);
                rd_inc = st_q.rd + AW'(1);
            end
        end else begin : g_wrap
            always_comb begin
                wr_inc = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + AW'(1);
                rd_inc = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + AW'(1);
            end
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.wr = wr_inc;
        end
        if (pop) begin
            st_d.rd = rd_inc;
        end
        case ({push, pop})
            2'b10:   st_d.fill = st_q.fill + CW'(1);
            2'b01:   st_d.fill = st_q.fill - CW'(1);
            default: st_d.fill = st_q.fill;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr = st_q.wr;
    assign rd_ptr = st_q.rd;
    assign fill   = st_q.fill;
    assign full   = (st_q.fill == CW'(DEPTH));
    assign empty  = (st_q.fill == '0);

endmodule

// File: rtl/ifb_ctrl.sv
module ifb_ctrl
    import inband_fifo_pkg::*;
#(
    parameter int ERASE_LEN = 128,
    localparam int EW = (ERASE_LEN > 1) ? $clog2(ERASE_LEN) : 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_stb,
    input  logic      rd_stb,
    input  logic      full,
    input  logic      empty,
    output logic      push,
    output logic      pop,
    output ifb_src_e  src,
    output ifb_mode_e mode
);

    typedef struct packed {
        ifb_mode_e     mode;
        logic [EW-1:0] ecnt;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic       ecnt_last;

    assign ecnt_last = (st_q.ecnt == EW'(ERASE_LEN - 1));

    always_comb begin
        st_d = st_q;
        push = 1'b0;
        pop  = 1'b0;
        src  = SRC_NONE;
        unique case (st_q.mode)
            MODE_RUN: begin
                // Room exists, or a same-cycle read frees the head slot
                push = wr_stb && (!full || rd_stb);
                pop  = rd_stb && !empty;
                if (rd_stb) begin
                    src = empty ? SRC_NULL : SRC_MEM;
                end
                if (wr_stb && full && !rd_stb) begin
                    st_d.mode = MODE_LOST;
                    st_d.ecnt = '0;
                end
            end
            MODE_LOST: begin
                // All writes discarded until the erasure run completes
                pop = rd_stb && !empty;
                if (rd_stb) begin
                    if (!empty) begin
                        src = SRC_MEM;
                    end else begin
                        src = SRC_ERASE;
                        if (ecnt_last) begin
                            st_d.mode = MODE_RUN;
                            st_d.ecnt = '0;
                        end else begin
                            st_d.ecnt = st_q.ecnt + EW'(1);
                        end
                    end
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_RUN, ecnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.mode;

endmodule

// File: rtl/inband_fifo.sv
module inband_fifo
    import inband_fifo_pkg::*;
#(
    parameter int DEPTH     = 128,
    parameter int WIDTH     = 8,
    parameter int ERASE_LEN = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_stb,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_oe
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             oe;
    } out_state_t;

    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    fill;
    logic             full, empty;
    logic             push, pop;
    ifb_src_e         src;
    ifb_mode_e        mode;
    logic [WIDTH-1:0] mem_rdata;
    out_state_t       out_d, out_q;

    ifb_ctrl #(.ERASE_LEN(ERASE_LEN)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .rd_stb (rd_stb),
        .full   (full),
        .empty  (empty),
        .push   (push),
        .pop    (pop),
        .src    (src),
        .mode   (mode)
    );

    ifb_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .pop    (pop),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .fill   (fill),
        .full   (full),
        .empty  (empty)
    );

    ifb_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk    (clk),
        .we     (push),
        .waddr  (wr_ptr),
        .wdata  (wr_data),
        .raddr  (rd_ptr),
        .rdata  (mem_rdata)
    );

    always_comb begin
        out_d.oe = (src != SRC_NONE);
        unique case (src)
            SRC_MEM:   out_d.data = mem_rdata;
            SRC_ERASE: out_d.data = '1;
            default:   out_d.data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rd_oe   = out_q.oe;
    assign rd_data = out_q.data;

endmodule

// File: rtl/ifb_chk.sv
module ifb_chk
    import inband_fifo_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int WIDTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_stb,
    input logic             rd_stb,
    input logic [WIDTH-1:0] rd_data,
    input logic             rd_oe,
    input logic [CW-1:0]    fill,
    input logic             full,
    input logic             empty,
    input logic             push,
    input ifb_mode_e        mode
);

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH)); // R1

    AST_EMPTY_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && empty && rd_stb) |=> (rd_oe && rd_data == '0)); // R3

    AST_OVF_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && full && wr_stb && !rd_stb) |=> (mode == MODE_LOST && full)); // R4

    AST_ERASE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOST && empty && rd_stb) |=> (rd_oe && rd_data == '1)); // R5

    AST_LOST_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOST) |-> !push); // R6

    AST_OE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_oe); // R7

    AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> (!rd_oe && rd_data == '0)); // R7

    AST_FULL_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && full && wr_stb && rd_stb) |=> (mode == MODE_RUN && full)); // R8

endmodule

bind inband_fifo ifb_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .rd_stb  (rd_stb),
    .rd_data (rd_data),
    .rd_oe   (rd_oe),
    .fill    (fill),
    .full    (full),
    .empty   (empty),
    .push    (push),
    .mode    (mode)
);

// File: tb/tb_inband_fifo.sv
module tb_inband_fifo;

    localparam int DEPTH = 128;
    localparam int ELEN  = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       rd_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk; // 50 MHz

    inband_fifo #(.DEPTH(DEPTH), .WIDTH(8), .ERASE_LEN(ELEN)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .rd_stb  (rd_stb),
        .rd_data (rd_data),
        .rd_oe   (rd_oe)
    );

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((i * 37 + seed * 11 + 5) & 8'hFF);
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, let the rising edge sample, return at next falling edge
    task automatic step(input logic w, input logic [7:0] d, input logic r);
        wr_stb  = w;
        wr_data = d;
        rd_stb  = r;
        @(posedge clk);
        @(negedge clk);
        wr_stb = 1'b0;
        rd_stb = 1'b0;
    endtask

    task automatic rd_expect(input logic [7:0] exp, input string req);
        step(1'b0, 8'h00, 1'b1);
        check(rd_data, exp, req);
        check({7'd0, rd_oe}, 8'd1, {req, " oe"});
    endtask

    task automatic fill_n(input int seed, input int n);
        for (int i = 0; i < n; i++) step(1'b1, pat(seed, i), 1'b0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin : stim
        @(negedge clk);
        @(negedge clk);
        // R2: reset state
        check(rd_data, 8'h00, "R2 data");
        check({7'd0, rd_oe}, 8'd0, "R2 oe");
        rst_n = 1'b1;
        @(negedge clk);
        rd_expect(8'h00, "R2 first read");

        // R3: repeated empty reads, nothing consumed
        for (int i = 0; i < 4; i++) rd_expect(8'h00, "R3 empty");
        // R7: idle cycle drops enable and data
        step(1'b0, 8'h00, 1'b0);
        check({7'd0, rd_oe}, 8'd0, "R7 idle oe");
        check(rd_data, 8'h00, "R7 idle data");

        // R1: sweep of fill lengths, in-order readback, then null
        for (int n = 1; n <= DEPTH; n = n * 2 + 1) begin
            fill_n(n, n);
            for (int i = 0; i < n; i++) rd_expect(pat(n, i), "R1 order");
            rd_expect(8'h00, "R3 after drain");
        end
        fill_n(3, DEPTH);
        for (int i = 0; i < DEPTH; i++) rd_expect(pat(3, i), "R1 full depth");
        rd_expect(8'h00, "R3 after full drain");

        // R8: read and write together while full
        fill_n(4, DEPTH);
        for (int k = 0; k < 5; k++) begin
            step(1'b1, pat(5, k), 1'b1);
            check(rd_data, pat(4, k), "R8 xfer head");
        end
        for (int i = 5; i < DEPTH; i++) rd_expect(pat(4, i), "R8 remaining");
        for (int k = 0; k < 5; k++) rd_expect(pat(5, k), "R8 tail");
        rd_expect(8'h00, "R8 no overflow");

        // R4/R5/R6: overflow, writes discarded, stored data then erasure run
        fill_n(6, DEPTH);
        step(1'b1, 8'hA5, 1'b0);           // R4 overflowing write
        for (int k = 0; k < 3; k++) step(1'b1, 8'h5A, 1'b0); // R6 discarded
        for (int i = 0; i < DEPTH; i++) rd_expect(pat(6, i), "R4 stored kept");
        for (int i = 0; i < ELEN; i++) begin
            if (i % 16 == 0) step(1'b1, 8'h33, 1'b0);        // R6 discarded
            rd_expect(8'hFF, "R5 erasure");
        end
        rd_expect(8'h00, "R5 latch cleared");
        rd_expect(8'h00, "R6 nothing leaked");

        // R9: normal operation resumes
        fill_n(7, 3);
        for (int i = 0; i < 3; i++) rd_expect(pat(7, i), "R9 resume");
        rd_expect(8'h00, "R9 empty after");

        // R6: room freed by reads during the latched period still refuses writes
        fill_n(8, DEPTH);
        step(1'b1, 8'hC3, 1'b0);
        for (int i = 0; i < 10; i++) rd_expect(pat(8, i), "R4 partial drain");
        for (int k = 0; k < 5; k++) step(1'b1, 8'h77, 1'b0);
        for (int i = 10; i < DEPTH; i++) rd_expect(pat(8, i), "R6 drain rest");
        for (int i = 0; i < ELEN; i++) rd_expect(8'hFF, "R5 erasure 2");
        rd_expect(8'h00, "R6 no late bytes");

        finish_run();
    end

endmodule